// File: doc/BRIEF.md
# Reload-Table Trigger Timer

This block is an up-counting timer that spaces out conversion triggers for a grouped conversion sequencer. Each time the counter passes its reload value, the block emits a one-cycle update pulse. That pulse starts the next conversion group. On the same clock edge the block takes the next period from a small preloaded table, so the gaps between consecutive groups can differ from one another without any software work during a round.

Software writes the table entries and the number of entries in use, and sets the first period through the reload write port while the timer is stopped. It then enables counting. The table supplies one new period per update. When the table is used up, the period stays as it is. A software write made while the timer runs is held until the first update that finds the table exhausted. A rearm input puts the table pointer back to its first entry for the next round.

Top module: `reload_table_timer`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), update_o is low, reload_o equals the parameter RST_RELOAD, the counter is zero and the table pointer is at entry 0.
- R2: With run_en_i high, the counter steps from 0 up to reload_o inclusive and then wraps. update_o is high for exactly the one cycle that follows each wrap, so pulses are reload_o+1 cycles apart. The first pulse comes reload_o+1 cycles after run_en_i rises.
- R3: While run_en_i is low, the counter is held at zero and update_o stays low. Enabling always begins a fresh period from zero and gives no immediate pulse.
- R4: At an update where the pointer is below the effective table length, reload_o takes the table entry at the pointer and the pointer advances by one. That value governs the period that begins with this update.
- R5: At an update where the pointer has reached the effective length and no software write is held, reload_o keeps its value.
- R6: A reload write (sw_wr_i) while run_en_i is low changes reload_o on the next cycle, and it discards any held write.
- R7: A reload write while run_en_i is high is held. It is applied at the first update that finds the table exhausted. At updates where table entries remain, the table entry wins and the write stays held.
- R8: rearm_i sets the pointer to entry 0. If rearm_i coincides with an update, that update already fetches entry 0 and leaves the pointer at 1.
- R9: tbl_len_i values above TBL_DEPTH are treated as TBL_DEPTH. Entry i is written through tbl_wr_i with tbl_idx_i = i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en_i | input | 1 | Counting enable |
| sw_wr_i | input | 1 | Reload value write strobe |
| sw_reload_i | input | CNT_W | Reload value to write |
| tbl_wr_i | input | 1 | Table entry write strobe |
| tbl_idx_i | input | $clog2(TBL_DEPTH) | Table entry index |
| tbl_val_i | input | CNT_W | Table entry value |
| tbl_len_i | input | $clog2(TBL_DEPTH+1) | Number of table entries in use |
| rearm_i | input | 1 | Return table pointer to entry 0 |
| update_o | output | 1 | One-cycle update (trigger) pulse |
| reload_o | output | CNT_W | Reload value now in force |

## Verification
The embedded properties rely on three conditions: reset is applied synchronously before any other activity, tbl_idx_i always addresses an existing entry, and the reload value changes only at a wrap or while counting is disabled. Under that last condition the counter can never exceed the reload value. The stimulus respects all three. It writes table slots only through valid indices, writes the reload register either while stopped or as a held write, and keeps every period at two or more cycles so that successive pulses stay separated. The random rounds draw table contents, lengths above and below the depth, and start periods from a fixed seed. Directed cases cover the held write, the rearm that lands on an update, and the disabled interval.

// File: rtl/rtt_pkg.sv
// Package: shared types of the reload-table timer.
// Assumes nothing beyond the standard language.
package rtt_pkg;

    // Which source feeds the reload register at a given edge.
    typedef enum logic [1:0] {
        SRC_HOLD  = 2'd0,
        SRC_TABLE = 2'd1,
        SRC_SOFT  = 2'd2,
        SRC_DIRECT = 2'd3
    } reload_src_e;

endpackage

// File: rtl/rtt_counter.sv
// Module: rtt_counter
// Up-counter from zero to the active reload value inclusive. It signals a wrap
// combinationally and registers the update pulse. Assumes the reload value
// changes only at a wrap or while disabled.
module rtt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] active,
    output logic             wrap,
    output logic             update_o
);

    logic [CNT_W-1:0] cnt_q;

    // Wrap happens on the cycle where the count sits at the reload value.
    always_comb wrap = en && (cnt_q == active);

    // Count while enabled, hold at zero while off, pulse after each wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            update_o <= 1'b0;
        end else if (!en) begin
            cnt_q    <= '0;
            update_o <= 1'b0;
        end else if (wrap) begin
            cnt_q    <= '0;
            update_o <= 1'b1;
        end else begin
            cnt_q    <= cnt_q + 1'b1;
            update_o <= 1'b0;
        end
    end

    // R2: the count never passes the reload value
    a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= active);

    // R2: an update pulse always marks the start of a fresh period
    a_r2_pulse_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        update_o |-> (cnt_q == '0));

    // R3: disabled means quiet and held at zero on the next cycle
    a_r3_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!update_o && cnt_q == '0));

endmodule

// File: rtl/rtt_table.sv
// Module: rtt_table
// Small table of reload values with a read pointer. On a wrap it offers the
// entry at the pointer and advances. Assumes TBL_DEPTH >= 2 and that writes
// use an index below TBL_DEPTH.
module rtt_table #(
    parameter int CNT_W     = 16,
    parameter int TBL_DEPTH = 4,
    localparam int IDX_W    = $clog2(TBL_DEPTH),
    localparam int LEN_W    = $clog2(TBL_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [IDX_W-1:0] idx,
    input  logic [CNT_W-1:0] val,
    input  logic [LEN_W-1:0] len,
    input  logic             rearm,
    input  logic             wrap,
    output logic             fetch_valid,
    output logic [CNT_W-1:0] fetch_data
);

    localparam logic [LEN_W-1:0] DEPTH_L = LEN_W'(TBL_DEPTH);

    logic [CNT_W-1:0] mem_q [TBL_DEPTH];
    logic [LEN_W-1:0] ptr_q;
    logic [LEN_W-1:0] eff_ptr;
    logic [LEN_W-1:0] eff_len;

    // Storage for each entry, one register per slot.
    for (genvar g = 0; g < TBL_DEPTH; g++) begin : g_slot
        // Capture a write addressed to this slot.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem_q[g] <= '0;
            else if (wr && (idx == IDX_W'(g)))
                mem_q[g] <= val;
        end
    end

    // Clamp the length, apply a rearm that coincides with a wrap, and select the entry.
    always_comb begin
        eff_len     = (len > DEPTH_L) ? DEPTH_L : len;
        eff_ptr     = rearm ? '0 : ptr_q;
        fetch_valid = eff_ptr < eff_len;
        fetch_data  = mem_q[eff_ptr[IDX_W-1:0]];
    end

    // Advance the pointer on a fetching wrap, or reset it on a rearm.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (wrap && fetch_valid)
            ptr_q <= eff_ptr + 1'b1;
        else
            ptr_q <= eff_ptr;
    end

    // R9: pointer never runs past the table depth
    a_r9_ptr_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q <= DEPTH_L);

    // R4: a fetching wrap moves the pointer exactly one entry on
    a_r4_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && fetch_valid) |=> ptr_q == $past(eff_ptr) + 1'b1);

    // R8: a rearm without a wrap leaves the pointer at entry zero
    a_r8_rearm_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rearm && !wrap) |=> ptr_q == '0);

endmodule

// File: rtl/rtt_reload.sv
// Module: rtt_reload
// Reload register with a held software value. A wrap loads a table entry if
// one is offered, else a held software write. While stopped, software writes
// go straight in. Assumes wrap only asserts while enabled.
module rtt_reload
    import rtt_pkg::*;
#(
    parameter int               CNT_W      = 16,
    parameter logic [CNT_W-1:0] RST_RELOAD = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             wrap,
    input  logic             sw_wr,
    input  logic [CNT_W-1:0] sw_data,
    input  logic             fetch_valid,
    input  logic [CNT_W-1:0] fetch_data,
    output logic [CNT_W-1:0] active
);

    logic [CNT_W-1:0] hold_q;
    logic             pend_q;
    reload_src_e      src;

    // Pick the source for this edge: direct write, table, held write or keep.
    always_comb begin
        if (!en)
            src = sw_wr ? SRC_DIRECT : SRC_HOLD;
        else if (wrap && fetch_valid)
            src = SRC_TABLE;
        else if (wrap && pend_q)
            src = SRC_SOFT;
        else
            src = SRC_HOLD;
    end

    // Update the reload register from the chosen source.
    always_ff @(posedge clk) begin
        if (!rst_n)
            active <= RST_RELOAD;
        else begin
            unique case (src)
                SRC_DIRECT: active <= sw_data;
                SRC_TABLE:  active <= fetch_data;
                SRC_SOFT:   active <= hold_q;
                default:    active <= active;
            endcase
        end
    end

    // Keep the latest running-time software write until it is consumed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            pend_q <= 1'b0;
        end else if (!en) begin
            pend_q <= 1'b0;
        end else if (sw_wr) begin
            hold_q <= sw_data;
            pend_q <= 1'b1;
        end else if (src == SRC_SOFT) begin
            pend_q <= 1'b0;
        end
    end

    // R5: while running, the reload value moves only at a wrap
    a_r5_steady_between_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !wrap) |=> active == $past(active));

    // R6: a stopped-time write is in force on the next cycle
    a_r6_direct_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && sw_wr) |=> active == $past(sw_data));

    // R7: a table entry outranks a held write at the same wrap
    a_r7_table_first: assert property (@(posedge clk) disable iff (!rst_n)
        (en && wrap && fetch_valid) |=> active == $past(fetch_data));

endmodule

// File: rtl/reload_table_timer.sv
// Module: reload_table_timer (top)
// Timer whose wrap pulse triggers a conversion group and whose period comes
// from a preloaded table, one entry per wrap. Assumes synchronous reset and
// table indices below TBL_DEPTH.
module reload_table_timer #(
    parameter int               CNT_W      = 16,
    parameter int               TBL_DEPTH  = 4,
    parameter logic [CNT_W-1:0] RST_RELOAD = CNT_W'(999),
    localparam int              IDX_W      = $clog2(TBL_DEPTH),
    localparam int              LEN_W      = $clog2(TBL_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en_i,
    input  logic             sw_wr_i,
    input  logic [CNT_W-1:0] sw_reload_i,
    input  logic             tbl_wr_i,
    input  logic [IDX_W-1:0] tbl_idx_i,
    input  logic [CNT_W-1:0] tbl_val_i,
    input  logic [LEN_W-1:0] tbl_len_i,
    input  logic             rearm_i,
    output logic             update_o,
    output logic [CNT_W-1:0] reload_o
);

    logic             wrap;
    logic             fetch_valid;
    logic [CNT_W-1:0] fetch_data;

    rtt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (run_en_i),
        .active   (reload_o),
        .wrap     (wrap),
        .update_o (update_o)
    );

    rtt_table #(.CNT_W(CNT_W), .TBL_DEPTH(TBL_DEPTH)) u_tbl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr          (tbl_wr_i),
        .idx         (tbl_idx_i),
        .val         (tbl_val_i),
        .len         (tbl_len_i),
        .rearm       (rearm_i),
        .wrap        (wrap),
        .fetch_valid (fetch_valid),
        .fetch_data  (fetch_data)
    );

    rtt_reload #(.CNT_W(CNT_W), .RST_RELOAD(RST_RELOAD)) u_rld (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (run_en_i),
        .wrap        (wrap),
        .sw_wr       (sw_wr_i),
        .sw_data     (sw_reload_i),
        .fetch_valid (fetch_valid),
        .fetch_data  (fetch_data),
        .active      (reload_o)
    );

    // R1: reset leaves the pulse low and the reload at its reset value
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (!update_o && reload_o == RST_RELOAD));

endmodule

// File: tb/reload_table_timer_tb_top.sv
`timescale 1ns/1ps
module reload_table_timer_tb_top;

    localparam int CNT_W = 16;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en_i = 1'b0;
    logic        sw_wr_i = 1'b0;
    logic [15:0] sw_reload_i = '0;
    logic        tbl_wr_i = 1'b0;
    logic [1:0]  tbl_idx_i = '0;
    logic [15:0] tbl_val_i = '0;
    logic [2:0]  tbl_len_i = '0;
    logic        rearm_i = 1'b0;
    logic        update_o;
    logic [15:0] reload_o;

    int nchk  = 0;
    int nfail = 0;
    bit done  = 0;

    int tbl_m [DEPTH];
    int len_m;
    int start_m;

    always #4 clk = ~clk;

    reload_table_timer dut_i (
        .clk(clk), .rst_n(rst_n), .run_en_i(run_en_i),
        .sw_wr_i(sw_wr_i), .sw_reload_i(sw_reload_i),
        .tbl_wr_i(tbl_wr_i), .tbl_idx_i(tbl_idx_i), .tbl_val_i(tbl_val_i),
        .tbl_len_i(tbl_len_i), .rearm_i(rearm_i),
        .update_o(update_o), .reload_o(reload_o)
    );

    task automatic chk(string req, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // Count negedges until update_o is seen; strobes drop after the first one.
    task automatic wait_pulse(output int n);
        n = 0;
        forever begin
            @(negedge clk);
            n++;
            sw_wr_i = 1'b0;
            rearm_i = 1'b0;
            if (update_o) break;
            if (n >= 500) begin
                chk("watchdog pulse", n, -1);
                break;
            end
        end
    endtask

    task automatic wr_tbl(int i, int v);
        tbl_wr_i = 1'b1; tbl_idx_i = 2'(i); tbl_val_i = 16'(v);
        tick();
        tbl_wr_i = 1'b0;
    endtask

    // Expected gap before the k-th pulse of a round (k from 1).
    function automatic int exp_gap(int k);
        int r   = start_m;
        int lim = (len_m > DEPTH) ? DEPTH : len_m;
        for (int j = 1; j < k; j++)
            if (j - 1 < lim) r = tbl_m[j - 1];
        return r + 1;
    endfunction

    initial begin
        #(8 * 150000);
        if (!done) begin
            nfail++; nchk++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        int n;
        int seen;
        void'($urandom(32'd4711));
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk("R1 update low", update_o, 0);
        chk("R1 reload reset", reload_o, 999);

        // Directed round: table {6,4}, start period 9.
        wr_tbl(0, 6); wr_tbl(1, 4);
        tbl_len_i = 3'd2;
        sw_wr_i = 1'b1; sw_reload_i = 16'd9;
        tick();
        sw_wr_i = 1'b0;
        chk("R6 direct write", reload_o, 9);
        run_en_i = 1'b1;
        wait_pulse(n); chk("R2 first gap", n, 10);
        chk("R4 entry0 loaded", reload_o, 6);
        wait_pulse(n); chk("R4 gap from entry0", n, 7);
        chk("R4 entry1 loaded", reload_o, 4);
        wait_pulse(n); chk("R4 gap from entry1", n, 5);
        chk("R5 exhausted keeps", reload_o, 4);
        wait_pulse(n); chk("R5 gap unchanged", n, 5);
        sw_wr_i = 1'b1; sw_reload_i = 16'd12;
        wait_pulse(n); chk("R7 held until update", n, 5);
        chk("R7 held applied", reload_o, 12);
        wait_pulse(n); chk("R7 new period", n, 13);

        // Disabled interval.
        run_en_i = 1'b0;
        seen = 0;
        for (int i = 0; i < 30; i++) begin
            tick();
            if (update_o) seen++;
        end
        chk("R3 no pulse while off", seen, 0);
        chk("R3 reload kept while off", reload_o, 12);

        // Rearm, then a running write while entries remain.
        rearm_i = 1'b1;
        tick();
        rearm_i = 1'b0;
        run_en_i = 1'b1;
        sw_wr_i = 1'b1; sw_reload_i = 16'd20;
        wait_pulse(n); chk("R3 fresh period", n, 13);
        chk("R7 table wins", reload_o, 6);
        wait_pulse(n); chk("R8 rearm restart gap", n, 7);
        chk("R7 table wins again", reload_o, 4);
        wait_pulse(n); chk("R7 held after table", n, 5);
        chk("R7 held applied late", reload_o, 20);
        wait_pulse(n); chk("R7 held period", n, 21);

        // Rearm coinciding with an update.
        seen = 0;
        for (int i = 0; i < 20; i++) begin
            tick();
            if (update_o) seen++;
        end
        chk("R2 no early pulse", seen, 0);
        rearm_i = 1'b1;
        tick();
        rearm_i = 1'b0;
        chk("R8 pulse at rearm edge", update_o, 1);
        chk("R8 entry0 fetched", reload_o, 6);
        wait_pulse(n); chk("R8 gap after rearm", n, 7);
        chk("R8 pointer at 1", reload_o, 4);

        // Random rounds.
        for (int r = 0; r < 8; r++) begin
            run_en_i = 1'b0;
            tick();
            for (int i = 0; i < DEPTH; i++) begin
                tbl_m[i] = $urandom_range(25, 2);
                wr_tbl(i, tbl_m[i]);
            end
            len_m = (r == 0) ? 7 : (r == 1) ? 0 : $urandom_range(6, 0);
            tbl_len_i = 3'(len_m);
            rearm_i = 1'b1;
            tick();
            rearm_i = 1'b0;
            start_m = $urandom_range(25, 2);
            sw_wr_i = 1'b1; sw_reload_i = 16'(start_m);
            tick();
            sw_wr_i = 1'b0;
            run_en_i = 1'b1;
            for (int k = 1; k <= 6; k++) begin
                wait_pulse(n);
                chk("R4 R5 R9 random gap", n, exp_gap(k));
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule